// File: doc/BRIEF.md
# Two-Road Junction Signal Controller

This block runs the signals at a crossing of a main road and a side road. Each road has a red, amber and green lamp and one car-presence sensor. One road holds the right of way at a time. After reset the main road holds it. The right of way moves only when a car has been seen at the road that shows red. A move starts only after a set wait interval and a minimum green time have both run out.

Every changeover follows the same sequence. The road that is losing the right of way shows amber, then both roads show red for a short gap, then the other road goes straight from red to green. The wait interval, minimum green, amber time and all-red time are parameters counted in clock cycles.

The sensors are asynchronous to the clock, so each one passes through a two-flop synchronizer. A request is latched when it is seen. This means a car that leaves during the wait still completes the changeover. Reset is synchronous and active-high.

Top module: `junction_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `main_lamp` is 3'b100 (green) and `side_lamp` is 3'b001 (red). Lamp bit 0 is red, bit 1 is amber and bit 2 is green.
- R2: With no car reported at the road showing red, both lamp outputs keep their values for any number of cycles.
- R3: `main_lamp[2]` and `side_lamp[2]` are never both high.
- R4: A road leaving green shows amber for exactly AMBER_CYC cycles, then red.
- R5: After the amber, both roads show red for exactly ALLRED_CYC cycles. The other road then goes straight from red to green, with no amber.
- R6: A request is latched on the third rising edge after the red road's sensor goes high. Amber then starts on the edge after that request has been held for WAIT_CYC cycles, provided the minimum green has also run out.
- R7: Once latched, a request completes the changeover even if the sensor drops after a single cycle.
- R8: A road that has just turned green keeps green for MIN_GREEN_CYC+1 cycles when the other road's request is already pending.
- R9: A sensor change reaches the request logic only after two register stages. A level applied before edge k is first acted on at edge k+2.
- R10: Each lamp output has exactly one bit set in every cycle.
- R11: The sensor of the road that currently shows green has no effect on either lamp output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_car | input | 1 | Car present on the main road (asynchronous) |
| side_car | input | 1 | Car present on the side road (asynchronous) |
| main_lamp | output | 3 | Main road lamps: bit0 red, bit1 amber, bit2 green |
| side_lamp | output | 3 | Side road lamps: bit0 red, bit1 amber, bit2 green |

## Verification
The assertions assume that AMBER_CYC and ALLRED_CYC are at least one. They also assume the sensor inputs are sampled only through the synchronizer, so a pulse shorter than a clock period may be missed. The bench drives the sensors on falling edges and holds every level for at least one full cycle. The random phase changes the sensor levels only on multi-cycle boundaries. A behavioural reference model tracks phase age, request age and synchronizer delay, and the bench compares it with both lamp outputs on every cycle.

// File: rtl/jc_pkg.sv
package jc_pkg;

  typedef enum logic [2:0] {
    ST_MAIN_GO     = 3'd0,
    ST_MAIN_AMB    = 3'd1,
    ST_CLR_TO_SIDE = 3'd2,
    ST_SIDE_GO     = 3'd3,
    ST_SIDE_AMB    = 3'd4,
    ST_CLR_TO_MAIN = 3'd5
  } jc_state_e;

  localparam logic [2:0] LAMP_RED = 3'b001;
  localparam logic [2:0] LAMP_AMB = 3'b010;
  localparam logic [2:0] LAMP_GRN = 3'b100;

  function automatic logic is_go(jc_state_e s);
    return (s == ST_MAIN_GO) || (s == ST_SIDE_GO);
  endfunction

  function automatic logic is_amber(jc_state_e s);
    return (s == ST_MAIN_AMB) || (s == ST_SIDE_AMB);
  endfunction

  function automatic jc_state_e succ(jc_state_e s);
    case (s)
      ST_MAIN_GO:     return ST_MAIN_AMB;
      ST_MAIN_AMB:    return ST_CLR_TO_SIDE;
      ST_CLR_TO_SIDE: return ST_SIDE_GO;
      ST_SIDE_GO:     return ST_SIDE_AMB;
      ST_SIDE_AMB:    return ST_CLR_TO_MAIN;
      default:        return ST_MAIN_GO;
    endcase
  endfunction

  function automatic logic [2:0] main_lamp_of(jc_state_e s);
    case (s)
      ST_MAIN_GO:  return LAMP_GRN;
      ST_MAIN_AMB: return LAMP_AMB;
      default:     return LAMP_RED;
    endcase
  endfunction

  function automatic logic [2:0] side_lamp_of(jc_state_e s);
    case (s)
      ST_SIDE_GO:  return LAMP_GRN;
      ST_SIDE_AMB: return LAMP_AMB;
      default:     return LAMP_RED;
    endcase
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/jc_sync.sv
module jc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= '0;
          else     stg[gi] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= '0;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/jc_dntimer.sv
module jc_dntimer #(
  parameter int            TW      = 4,
  parameter logic [TW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  output logic          done
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= RST_VAL;
    else if (ld)           cnt <= ld_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_TMR_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (rst)
    (done && !ld) |=> done); // R4

endmodule

// File: rtl/jc_fsm.sv
module jc_fsm
  import jc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       main_car_s,
  input  logic       side_car_s,
  input  logic       go_done,
  input  logic       wait_done,
  input  logic       ph_done,
  output logic       go_ld,
  output logic       wait_ld,
  output logic       ph_ld,
  output logic       ph_to_amb,
  output logic [2:0] main_lamp,
  output logic [2:0] side_lamp
);

  jc_state_e state, state_nxt;
  logic      req_q;
  logic      other_car;
  logic      take_turn;
  logic      phase_over;

  assign other_car  = (state == ST_MAIN_GO) ? side_car_s : main_car_s;
  assign take_turn  = is_go(state) && req_q && wait_done && go_done;
  assign phase_over = !is_go(state) && ph_done;
  assign state_nxt  = (take_turn || phase_over) ? succ(state) : state;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_MAIN_GO;
    else     state <= state_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                req_q <= 1'b0;
    else if (!is_go(state)) req_q <= 1'b0;
    else if (other_car)     req_q <= 1'b1;
  end

  assign go_ld     = !is_go(state);
  assign wait_ld   = !req_q;
  assign ph_ld     = (state_nxt != state);
  assign ph_to_amb = is_amber(state_nxt);
  assign main_lamp = main_lamp_of(state);
  assign side_lamp = side_lamp_of(state);

  AST_NEVER_BOTH_GREEN: assert property (@(posedge clk) disable iff (rst)
    !(main_lamp[2] && side_lamp[2])); // R3
  AST_LAMPS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    ($countones(main_lamp) == 1) && ($countones(side_lamp) == 1)); // R10
  AST_MAIN_GREEN_TO_AMBER: assert property (@(posedge clk) disable iff (rst)
    $fell(main_lamp[2]) |-> main_lamp[1]); // R4
  AST_SIDE_GREEN_TO_AMBER: assert property (@(posedge clk) disable iff (rst)
    $fell(side_lamp[2]) |-> side_lamp[1]); // R4
  AST_MAIN_GREEN_FROM_ALLRED: assert property (@(posedge clk) disable iff (rst)
    $rose(main_lamp[2]) |-> $past(main_lamp[0] && side_lamp[0])); // R5
  AST_SIDE_GREEN_FROM_ALLRED: assert property (@(posedge clk) disable iff (rst)
    $rose(side_lamp[2]) |-> $past(main_lamp[0] && side_lamp[0])); // R5
  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (is_go(state) && !req_q) |=> (state == $past(state))); // R2
  AST_CHANGE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(main_lamp[2]) || $fell(side_lamp[2])) |-> $past(req_q && wait_done)); // R6
  AST_CHANGE_NEEDS_MIN_GREEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(main_lamp[2]) || $fell(side_lamp[2])) |-> $past(go_done)); // R8

endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
  import jc_pkg::*;
#(
  parameter int WAIT_CYC      = 8,
  parameter int MIN_GREEN_CYC = 12,
  parameter int AMBER_CYC     = 3,
  parameter int ALLRED_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       main_car,
  input  logic       side_car,
  output logic [2:0] main_lamp,
  output logic [2:0] side_lamp
);

  localparam int MAXV = max_of(max_of(WAIT_CYC, MIN_GREEN_CYC), max_of(AMBER_CYC, ALLRED_CYC));
  localparam int TW   = bits_for(MAXV);
  localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC);
  localparam logic [TW-1:0] MING_LD = TW'(MIN_GREEN_CYC);
  localparam logic [TW-1:0] AMB_LD  = TW'(AMBER_CYC - 1);
  localparam logic [TW-1:0] CLR_LD  = TW'(ALLRED_CYC - 1);

  logic [1:0]    car_s;
  logic          go_done, wait_done, ph_done;
  logic          go_ld, wait_ld, ph_ld, ph_to_amb;
  logic [TW-1:0] ph_val;

  jc_sync #(.W(2), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({side_car, main_car}),
    .q_sync  (car_s)
  );

  jc_dntimer #(.TW(TW), .RST_VAL(MING_LD)) u_go_tmr (
    .clk(clk), .rst(rst), .ld(go_ld), .ld_val(MING_LD), .done(go_done)
  );

  jc_dntimer #(.TW(TW), .RST_VAL(WAIT_LD)) u_wait_tmr (
    .clk(clk), .rst(rst), .ld(wait_ld), .ld_val(WAIT_LD), .done(wait_done)
  );

  assign ph_val = ph_to_amb ? AMB_LD : CLR_LD;

  jc_dntimer #(.TW(TW), .RST_VAL('0)) u_ph_tmr (
    .clk(clk), .rst(rst), .ld(ph_ld), .ld_val(ph_val), .done(ph_done)
  );

  jc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .main_car_s (car_s[0]),
    .side_car_s (car_s[1]),
    .go_done    (go_done),
    .wait_done  (wait_done),
    .ph_done    (ph_done),
    .go_ld      (go_ld),
    .wait_ld    (wait_ld),
    .ph_ld      (ph_ld),
    .ph_to_amb  (ph_to_amb),
    .main_lamp  (main_lamp),
    .side_lamp  (side_lamp)
  );

  AST_RESET_MAIN_GREEN: assert property (@(posedge clk)
    $past(rst) |-> (main_lamp == LAMP_GRN && side_lamp == LAMP_RED)); // R1

endmodule

// File: tb/tb_junction_ctrl.sv
module tb_junction_ctrl;

  localparam int WAITC = 8;
  localparam int MING  = 12;
  localparam int AMBC  = 3;
  localparam int CLRC  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_car = 1'b0;
  logic side_car = 1'b0;
  logic [2:0] main_lamp, side_lamp;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  junction_ctrl #(.WAIT_CYC(WAITC), .MIN_GREEN_CYC(MING), .AMBER_CYC(AMBC),
                  .ALLRED_CYC(CLRC)) dut (
    .clk(clk), .rst(rst), .main_car(main_car), .side_car(side_car),
    .main_lamp(main_lamp), .side_lamp(side_lamp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 main go, 1 main amber, 2 clear, 3 side go, 4 side amber, 5 clear
  int m_phase, m_age, m_req_age;
  bit m_req;
  bit [1:0] m_s1, m_s2; // bit0 main, bit1 side

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_phase = 0; m_age = 0; m_req = 0; m_req_age = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit go_now;
      bit other;
      int nxt;
      go_now = (m_phase == 0) || (m_phase == 3);
      other  = (m_phase == 0) ? m_s2[1] : m_s2[0];
      nxt = m_phase;
      if (go_now) begin
        if (m_req && m_req_age >= WAITC && m_age >= MING) nxt = m_phase + 1;
      end else if (m_phase == 1 || m_phase == 4) begin
        if (m_age >= AMBC - 1) nxt = m_phase + 1;
      end else begin
        if (m_age >= CLRC - 1) nxt = (m_phase + 1) % 6;
      end
      if (!go_now) m_req = 0;
      else if (m_req) m_req_age++;
      else if (other) begin m_req = 1; m_req_age = 0; end
      if (nxt != m_phase) m_age = 0;
      else if (m_age < 100000) m_age++;
      m_phase = nxt;
      m_s2 = m_s1;
      m_s1 = {side_car, main_car};
    end
  end

  function automatic int exp_main(int p);
    return (p == 0) ? 4 : (p == 1) ? 2 : 1;
  endfunction
  function automatic int exp_side(int p);
    return (p == 3) ? 4 : (p == 4) ? 2 : 1;
  endfunction

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk(main_lamp == 3'(exp_main(m_phase)), "R6 main lamp trace", main_lamp, exp_main(m_phase));
      chk(side_lamp == 3'(exp_side(m_phase)), "R4 side lamp trace", side_lamp, exp_side(m_phase));
      chk(!(main_lamp[2] && side_lamp[2]), "R3 both green", {main_lamp[2], side_lamp[2]}, 0);
      chk($countones(main_lamp) == 1 && $countones(side_lamp) == 1, "R10 onehot",
          {main_lamp, side_lamp}, 0);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts falling edges until the chosen lamp equals val
  task automatic wait_lamp(input bit side, input logic [2:0] val, input int limit,
                           output int n);
    n = 0;
    while (((side ? side_lamp : main_lamp) != val) && n <= limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    wait (cyc > 60000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 60000);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int n;
    logic [15:0] lf;
    @(negedge clk);
    chk(main_lamp == 3'b100 && side_lamp == 3'b001, "R1 during reset",
        {main_lamp, side_lamp}, 6'b100001);
    tick(2);
    rst = 1'b0;
    @(negedge clk);
    chk(main_lamp == 3'b100 && side_lamp == 3'b001, "R1 after reset",
        {main_lamp, side_lamp}, 6'b100001);

    // R2: idle junction holds
    tick(150);
    chk(main_lamp == 3'b100 && side_lamp == 3'b001, "R2 idle hold",
        {main_lamp, side_lamp}, 6'b100001);

    // R11: sensor of green road has no effect
    main_car = 1'b1;
    tick(100);
    chk(main_lamp == 3'b100 && side_lamp == 3'b001, "R11 green road sensor",
        {main_lamp, side_lamp}, 6'b100001);
    main_car = 1'b0;
    tick(3);

    // R6 / R9: latency from side sensor to main amber = 2 sync + latch + WAIT + 1
    side_car = 1'b1;
    wait_lamp(1'b0, 3'b010, 200, n);
    chk(n == WAITC + 4, "R9 R6 request to amber", n, WAITC + 4);
    main_car = 1'b1;
    wait_lamp(1'b0, 3'b001, 50, n);
    chk(n == AMBC, "R4 amber length", n, AMBC);
    wait_lamp(1'b1, 3'b100, 50, n);
    chk(n == CLRC, "R5 all red length", n, CLRC);
    side_car = 1'b0;

    // R8: request pending already, green lasts MIN+1
    n = 0;
    while (side_lamp == 3'b100 && n < 200) begin @(negedge clk); n++; end
    chk(n == MING + 1, "R8 minimum green", n, MING + 1);
    chk(side_lamp == 3'b010, "R4 side amber after green", side_lamp, 3'b010);
    wait_lamp(1'b0, 3'b100, 50, n);
    chk(n == AMBC + CLRC, "R5 return to main", n, AMBC + CLRC);
    main_car = 1'b0;

    // R7: single-cycle pulse still completes changeover
    tick(30);
    side_car = 1'b1;
    @(negedge clk);
    side_car = 1'b0;
    wait_lamp(1'b1, 3'b100, 200, n);
    chk(side_lamp == 3'b100, "R7 latched pulse", side_lamp, 3'b100);
    tick(5);
    chk(side_lamp == 3'b100, "R2 side holds without request", side_lamp, 3'b100);

    // random stretch checked by the reference model
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      main_car = lf[3] & lf[7];
      side_car = lf[5] & lf[1];
      tick(1 + int'(lf[11:8]));
    end
    main_car = 1'b0;
    side_car = 1'b0;
    tick(60);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule